// File: doc/BRIEF.md
# Two-Digit Multiplexed Seven-Segment Scanner

This block shows a binary number from 0 to 99 on two common-anode seven-segment digits that share one set of segment lines. It splits the number into a tens digit and a units digit and lights one digit at a time. Each digit stays lit for a fixed number of clock cycles. Because the scan repeats quickly, the eye sees both digits lit at once.

Before each digit is lit, the block turns off both anodes and drives every segment line to its off level for a short blanking interval. This keeps one digit's pattern from showing faintly on the other. Inputs above 99 are clamped to 99. The input is captured once per scan, just before the tens digit lights, so both digits always come from the same number.

The scan is a four-state machine:
- `SC_BLANK_A`: dark, before the tens digit. This is the reset state.
- `SC_SHOW_A`: the tens digit is lit.
- `SC_BLANK_B`: dark, before the units digit.
- `SC_SHOW_B`: the units digit is lit.

The transitions are:
- blank-A to show-A when the blanking count ends. The input is captured at this transition.
- show-A to blank-B when the dwell count ends.
- blank-B to show-B when the blanking count ends.
- show-B back to blank-A when the dwell count ends.

No other transition exists.

Top module: `disp_scan_top`

## Requirements
- R1: While `rst` is high, and on the first cycle after it falls, `anode_en` is 00 and `seg_n` is 8'hFF. The first lit digit after reset is the tens digit.
- R2: The outputs cycle through four phases in a fixed order, repeating: blank, tens digit (`anode_en`=01), blank, units digit (`anode_en`=10).
- R3: Each lit phase lasts exactly `DWELL_CYC` clock cycles.
- R4: Each blanking phase lasts exactly `BLANK_CYC` clock cycles, with `anode_en`=00 and `seg_n`=8'hFF.
- R5: At most one bit of `anode_en` is high in any cycle. Whenever neither bit is high, `seg_n` is 8'hFF.
- R6: `seg_n` bit order is {dp,g,f,e,d,c,b,a} (bit 7 is dp, bit 0 is segment a), and a 0 lights a segment. The decimal point stays off (bit 7 = 1). Digits 0 to 9 light these segment sets (as active-high g..a): 3F, 06, 5B, 4F, 66, 6D, 7D, 07, 7F, 6F.
- R7: The tens digit shows value/10 and the units digit shows value%10. A leading zero is shown.
- R8: Any input above 99 is displayed as 99.
- R9: `value` is sampled only at the clock edge that ends the blanking phase before the tens digit. A change at any other time appears only in the next scan.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| value | input | VAL_W | Binary number to display |
| anode_en | output | 2 | Anode enables, active high; bit 0 = tens digit, bit 1 = units digit |
| seg_n | output | 8 | Segment lines, active low, {dp,g,f,e,d,c,b,a} |

## Verification
The bench builds the block with `DWELL_CYC`=12 and `BLANK_CYC`=3, so one full scan takes 30 cycles. With these values, ten complete scans fit in a few hundred cycles, and every phase length can be measured exactly. The bench changes `value` in the middle of each tens phase. This makes the capture rule of R9 visible on the units digit. The inputs include 0, single-digit numbers, 99, and values above 99, so both the clamp and the leading zero are exercised.

// File: rtl/disp_scan_pkg.sv
package disp_scan_pkg;

    typedef enum logic [1:0] {
        SC_BLANK_A = 2'd0,
        SC_SHOW_A  = 2'd1,
        SC_BLANK_B = 2'd2,
        SC_SHOW_B  = 2'd3
    } scan_st_e;

    localparam logic [7:0] SEG_DARK = 8'hFF;
    localparam int unsigned DISP_MAX = 99;

endpackage

// File: rtl/disp_digit_split.sv
module disp_digit_split #(
    parameter int unsigned VAL_W = 7
) (
    input  logic [VAL_W-1:0] bin_in,
    output logic [3:0]       tens,
    output logic [3:0]       units
);
    import disp_scan_pkg::*;

    localparam int unsigned STEPS = 9;

    logic [VAL_W-1:0] clamped;
    logic [STEPS-1:0] above;

    always_comb begin
        if (bin_in > VAL_W'(DISP_MAX)) begin
            clamped = VAL_W'(DISP_MAX);
        end else begin
            clamped = bin_in;
        end
    end

    // one comparator per decade threshold: 10, 20, ... 90
    for (genvar k = 0; k < STEPS; k++) begin : g_decade
        assign above[k] = (clamped >= VAL_W'((k + 1) * 10));
    end

    logic [VAL_W-1:0] tens_x10;

    always_comb begin
        tens = 4'd0;
        for (int k = 0; k < STEPS; k++) begin
            tens = tens + {3'd0, above[k]};
        end
        tens_x10 = VAL_W'(tens) * VAL_W'(10);
        units    = 4'(clamped - tens_x10);
    end

endmodule

// File: rtl/disp_seg_encode.sv
module disp_seg_encode (
    input  logic [3:0] digit,
    output logic [7:0] seg_n
);
    logic [6:0] lit;

    always_comb begin
        unique case (digit)
            4'd0:    lit = 7'h3F;
            4'd1:    lit = 7'h06;
            4'd2:    lit = 7'h5B;
            4'd3:    lit = 7'h4F;
            4'd4:    lit = 7'h66;
            4'd5:    lit = 7'h6D;
            4'd6:    lit = 7'h7D;
            4'd7:    lit = 7'h07;
            4'd8:    lit = 7'h7F;
            4'd9:    lit = 7'h6F;
            default: lit = 7'h00;
        endcase
        // decimal point is always dark, segments active low
        seg_n = {1'b1, ~lit};
    end

endmodule

// File: rtl/disp_scan_fsm.sv
module disp_scan_fsm #(
    parameter int unsigned DWELL_CYC = 250000,
    parameter int unsigned BLANK_CYC = 2
) (
    input  logic                      clk,
    input  logic                      rst,
    output disp_scan_pkg::scan_st_e   state,
    output logic                      capture
);
    import disp_scan_pkg::*;

    localparam int unsigned LONGEST = (DWELL_CYC > BLANK_CYC) ? DWELL_CYC : BLANK_CYC;
    localparam int unsigned CNT_W   = $clog2(LONGEST) + 1;

    scan_st_e           st_q, st_d;
    logic [CNT_W-1:0]   cnt_q;
    logic [CNT_W-1:0]   limit;
    logic               last;

    always_comb begin
        unique case (st_q)
            SC_SHOW_A, SC_SHOW_B:   limit = CNT_W'(DWELL_CYC - 1);
            SC_BLANK_A, SC_BLANK_B: limit = CNT_W'(BLANK_CYC - 1);
            default:                limit = '0;
        endcase
        last = (cnt_q == limit);
    end

    always_comb begin
        st_d = st_q;
        if (last) begin
            unique case (st_q)
                SC_BLANK_A: st_d = SC_SHOW_A;
                SC_SHOW_A:  st_d = SC_BLANK_B;
                SC_BLANK_B: st_d = SC_SHOW_B;
                SC_SHOW_B:  st_d = SC_BLANK_A;
                default:    st_d = SC_BLANK_A;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q  <= SC_BLANK_A;
            cnt_q <= '0;
        end else begin
            st_q  <= st_d;
            cnt_q <= last ? '0 : cnt_q + 1'b1;
        end
    end

    always_comb begin
        state   = st_q;
        capture = (st_q == SC_BLANK_A) && last;
    end

    assert_order_R2: assert property (@(posedge clk) disable iff (rst)
        (st_q == SC_SHOW_A) |=> (st_q == SC_SHOW_A || st_q == SC_BLANK_B));

    assert_wrap_R2: assert property (@(posedge clk) disable iff (rst)
        (st_q == SC_SHOW_B) |=> (st_q == SC_SHOW_B || st_q == SC_BLANK_A));

    assert_cnt_bound_R3: assert property (@(posedge clk) disable iff (rst)
        (st_q != $past(st_q)) |-> (cnt_q == '0));

endmodule

// File: rtl/disp_scan_top.sv
module disp_scan_top #(
    parameter int unsigned VAL_W     = 7,
    parameter int unsigned DWELL_CYC = 250000,
    parameter int unsigned BLANK_CYC = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [VAL_W-1:0] value,
    output logic [1:0]       anode_en,
    output logic [7:0]       seg_n
);
    import disp_scan_pkg::*;

    localparam int unsigned LONGEST = (DWELL_CYC > BLANK_CYC) ? DWELL_CYC : BLANK_CYC;
    localparam int unsigned HOLD_W  = $clog2(LONGEST) + 2;

    scan_st_e     state;
    logic         capture;
    logic [3:0]   tens_w, units_w;
    logic [3:0]   tens_q, units_q;
    logic [7:0]   tens_seg, units_seg;

    disp_scan_fsm #(
        .DWELL_CYC (DWELL_CYC),
        .BLANK_CYC (BLANK_CYC)
    ) u_fsm (
        .clk     (clk),
        .rst     (rst),
        .state   (state),
        .capture (capture)
    );

    disp_digit_split #(
        .VAL_W (VAL_W)
    ) u_split (
        .bin_in (value),
        .tens   (tens_w),
        .units  (units_w)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            tens_q  <= '0;
            units_q <= '0;
        end else if (capture) begin
            tens_q  <= tens_w;
            units_q <= units_w;
        end
    end

    disp_seg_encode u_enc_tens  (.digit(tens_q),  .seg_n(tens_seg));
    disp_seg_encode u_enc_units (.digit(units_q), .seg_n(units_seg));

    always_comb begin
        unique case (state)
            SC_SHOW_A: begin
                anode_en = 2'b01;
                seg_n    = tens_seg;
            end
            SC_SHOW_B: begin
                anode_en = 2'b10;
                seg_n    = units_seg;
            end
            SC_BLANK_A, SC_BLANK_B: begin
                anode_en = 2'b00;
                seg_n    = SEG_DARK;
            end
            default: begin
                anode_en = 2'b00;
                seg_n    = SEG_DARK;
            end
        endcase
    end

    // dwell checker: counts the cycles the anode pattern has held
    logic [1:0]        an_prev;
    logic [HOLD_W-1:0] hold_cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            an_prev  <= 2'b00;
            hold_cnt <= '0;
        end else begin
            an_prev  <= anode_en;
            hold_cnt <= (anode_en == an_prev) ? hold_cnt + 1'b1 : HOLD_W'(1);
        end
    end

    assert_reset_dark_R1: assert property (@(posedge clk)
        rst |=> (anode_en == 2'b00 && seg_n == SEG_DARK));

    assert_one_anode_R5: assert property (@(posedge clk) disable iff (rst)
        $onehot0(anode_en));

    assert_dark_when_off_R4: assert property (@(posedge clk) disable iff (rst)
        (anode_en == 2'b00) |-> (seg_n == SEG_DARK));

    assert_dwell_len_R3: assert property (@(posedge clk) disable iff (rst)
        (an_prev != 2'b00 && anode_en != an_prev) |-> (hold_cnt == HOLD_W'(DWELL_CYC)));

    assert_digit_range_R8: assert property (@(posedge clk) disable iff (rst)
        (tens_w <= 4'd9) && (units_w <= 4'd9));

    assert_hold_value_R9: assert property (@(posedge clk) disable iff (rst)
        !capture |=> ($stable(tens_q) && $stable(units_q)));

    assert_dp_off_R6: assert property (@(posedge clk) disable iff (rst)
        seg_n[7] == 1'b1);

endmodule

// File: tb/disp_scan_top_tb_top.sv
module disp_scan_top_tb_top;

    localparam int unsigned CLK_PERIOD = 10;
    localparam int unsigned VAL_W      = 7;
    localparam int unsigned DWELL      = 12;
    localparam int unsigned BLANK      = 3;
    localparam int unsigned SCAN       = 2 * (DWELL + BLANK);

    typedef struct {
        logic [1:0] an;
        logic [7:0] seg;
        int         len;
        string      tag;
    } exp_t;

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic [VAL_W-1:0] value = '0;
    logic [1:0]       anode_en;
    logic [7:0]       seg_n;

    int   checks   = 0;
    int   failures = 0;
    bit   done     = 1'b0;
    exp_t expq[$];

    always #(CLK_PERIOD / 2) clk = ~clk;

    disp_scan_top #(
        .VAL_W     (VAL_W),
        .DWELL_CYC (DWELL),
        .BLANK_CYC (BLANK)
    ) dut_i (
        .clk      (clk),
        .rst      (rst),
        .value    (value),
        .anode_en (anode_en),
        .seg_n    (seg_n)
    );

    function automatic logic [7:0] pattern(int d);
        logic [6:0] on;
        case (d)
            0: on = 7'h3F;  1: on = 7'h06;  2: on = 7'h5B;  3: on = 7'h4F;
            4: on = 7'h66;  5: on = 7'h6D;  6: on = 7'h7D;  7: on = 7'h07;
            8: on = 7'h7F;  default: on = 7'h6F;
        endcase
        return {1'b1, ~on};
    endfunction

    task automatic push_scan(int v);
        int    s;
        string extra;
        s     = (v > 99) ? 99 : v;
        extra = (v > 99) ? " R8" : "";
        expq.push_back('{2'b00, 8'hFF, BLANK, "R2 R4"});
        expq.push_back('{2'b01, pattern(s / 10), DWELL, {"R3 R6 R7", extra}});
        expq.push_back('{2'b00, 8'hFF, BLANK, "R4 R5"});
        expq.push_back('{2'b10, pattern(s % 10), DWELL, {"R3 R7 R9", extra}});
    endtask

    task automatic check_run(logic [1:0] an, logic [7:0] seg, int len);
        exp_t e;
        checks++;
        if (expq.size() == 0) begin
            failures++;
            $display("FAIL R2 unexpected phase an=%b seg=%h len=%0d expected none", an, seg, len);
            return;
        end
        e = expq.pop_front();
        if (an !== e.an || seg !== e.seg || len != e.len) begin
            failures++;
            $display("FAIL %s an=%b seg=%h len=%0d expected an=%b seg=%h len=%0d",
                     e.tag, an, seg, len, e.an, e.seg, e.len);
        end
    endtask

    // monitor: measures each constant-output phase and scores it
    initial begin
        logic [1:0] cur_an;
        logic [7:0] cur_seg;
        int         run;
        bit         started;
        started = 1'b0;
        run     = 0;
        cur_an  = '0;
        cur_seg = '0;
        forever begin
            @(negedge clk);
            if (!rst && !done) begin
                if (!started) begin
                    started = 1'b1;
                    cur_an  = anode_en;
                    cur_seg = seg_n;
                    run     = 1;
                end else if (anode_en === cur_an && seg_n === cur_seg) begin
                    run++;
                end else begin
                    check_run(cur_an, cur_seg, run);
                    cur_an  = anode_en;
                    cur_seg = seg_n;
                    run     = 1;
                end
            end
        end
    end

    // driver and reset checks
    initial begin
        int vals[10] = '{0, 7, 42, 99, 100, 127, 58, 10, 9, 90};
        value = VAL_W'(vals[0]);
        repeat (3) @(posedge clk);
        @(negedge clk);
        checks++;
        if (anode_en !== 2'b00 || seg_n !== 8'hFF) begin
            failures++;
            $display("FAIL R1 in reset an=%b seg=%h expected an=00 seg=ff", anode_en, seg_n);
        end
        @(posedge clk);
        #1 rst = 1'b0;
        checks++;
        if (anode_en !== 2'b00 || seg_n !== 8'hFF) begin
            failures++;
            $display("FAIL R1 after release an=%b seg=%h expected an=00 seg=ff", anode_en, seg_n);
        end
        for (int i = 0; i < 10; i++) begin
            push_scan(vals[i]);
            repeat (BLANK + 1) @(posedge clk);
            #1;
            if (i < 9) value = VAL_W'(vals[i + 1]);
            repeat (SCAN - BLANK - 1) @(posedge clk);
        end
        repeat (2) @(negedge clk);
        done = 1'b1;
        checks++;
        if (expq.size() != 0) begin
            failures++;
            $display("FAIL R2 phases left=%0d expected 0", expq.size());
        end
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        failures++;
        checks++;
        $display("FAIL R2 watchdog expired got hang expected finish");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule